// File: doc/BRIEF.md
# Instruction Word Decoder with Constant Substitution

This block takes one 16-bit instruction word per cycle. It sorts the word into one of three formats: two-operand, one-operand or conditional jump. It returns the control fields of the word one clock later. The fields are:

- the operation code
- the source and destination register numbers
- the byte/word select
- a classified source addressing mode and a classified destination addressing mode
- the number of extension words that follow the instruction
- for jumps, the branch displacement in bytes

Two registers get special handling when they are named as the source: the status register (number 2) and register 3. For certain mode bits these do not read a register. Instead they stand for a fixed constant, which the decoder returns directly, so no immediate word has to be fetched. The program counter (number 0) and register 2 also turn some indexed and auto-increment encodings into symbolic, absolute and immediate modes. This changes how many extension words the fetch unit must read.

A fetch stage uses the block by presenting a word with `in_valid` high. A cycle later it reads the fields, together with `ext_words`, which sets the program-counter advance of 2, 4 or 6 bytes. Operand access and execution are handled elsewhere.

Top module: `insn_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid` is 0 and every decoded output is 0.
- R2: The outputs for a word presented with `in_valid` high appear at the next rising clock edge, and `out_valid` then equals the `in_valid` of the cycle before. When `in_valid` is low, every decoded field keeps its value.
- R3: `fmt` encodes the format of the word:
  - 3 (jump) when bits 15:13 are 001.
  - 2 (one-operand) when bits 15:10 are 000100.
  - 1 (two-operand) when bits 15:12 are 4 or more.
  - 0 (illegal) otherwise. An illegal word gives 0 on every other field.
- R4: Two-operand words give:
  - `op` = bits 15:12
  - `src_reg` = bits 11:8
  - `dst_reg` = bits 3:0
  - the source mode from bits 5:4
  - the destination mode from bit 7
- R5: One-operand words give:
  - `op` = {0, bits 9:7}
  - `src_reg` = `dst_reg` = bits 3:0
  - the operand mode, decoded from bits 5:4 as a source mode, in `src_mode`
  - `dst_mode` = 0
- R6: Jump words give `op` = {0, bits 12:10} (condition) and `jmp_off` = bits 9:0 sign-extended to 16 bits and multiplied by 2. All other jump fields are 0.
- R7: Source mode codes are 0 REG, 1 IDX, 2 IND, 3 INC, 4 SYM, 5 ABS, 6 IMM and 7 CONST. With a source register other than 0, 2 or 3, mode bits 00/01/10/11 give REG/IDX/IND/INC.
- R8: With source register 0, mode bits 00/01/10/11 give REG/SYM/IND/IMM.
- R9: With source register 2:
  - mode bits 00 give REG.
  - mode bits 01 give ABS, with `const_val` 0 and `const_en` 0 (base 0).
  - mode bits 10 give CONST with value 4.
  - mode bits 11 give CONST with value 8.
- R10: With source register 3, every mode gives CONST with `const_en` 1, and the value is 0, 1, 2 or 0xFFFF for mode bits 00/01/10/11. In every other case `const_en` and `const_val` are 0.
- R11: For two-operand words, destination bit 7 = 0 gives REG (0). Bit 7 = 1 gives SYM (4) for register 0, ABS (5) for register 2 and IDX (1) otherwise.
- R12: `ext_words` counts one word for a source mode of IDX, SYM, ABS or IMM, and one more for a destination mode of IDX, SYM or ABS. CONST sources need no word.
- R13: `byte_op` equals bit 6 for two- and one-operand words, where 0 means word size. The word 0x4506 decodes as `fmt` 1, `op` 4, `src_reg` 5, `dst_reg` 6, REG/REG, `byte_op` 0 and `ext_words` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded fields valid |
| fmt | output | 2 | 0 illegal, 1 two-operand, 2 one-operand, 3 jump |
| op | output | 4 | Operation code or jump condition |
| src_reg | output | 4 | Source register number |
| dst_reg | output | 4 | Destination register number |
| byte_op | output | 1 | 1 = byte operation, 0 = word |
| src_mode | output | 3 | Classified source mode |
| dst_mode | output | 3 | Classified destination mode |
| const_en | output | 1 | Source is a generated constant |
| const_val | output | 16 | Generated constant value |
| ext_words | output | 2 | Extension words following (0 to 2) |
| jmp_off | output | 16 | Jump displacement in bytes |

## Verification
The directed words check that the classification works correctly in each kind of case:

- every source mode bit pair is paired with registers 0, 1, 2, 3 and a general register, so the symbolic, immediate, absolute and constant reinterpretations are each separated from the plain indexed and auto-increment cases;
- destinations indexed on registers 0, 2 and another register show the three one-word destination kinds apart;
- jumps with the largest positive and negative offsets, and words just outside the one-operand and jump ranges, test the sign extension and the format boundaries;
- idle cycles between words, and words sent while reset is held, show the outputs holding rather than tracking the input.

A long pseudo-random stream of words with a random valid then mixes all of these cases.

// File: rtl/insn_decoder.sv
module insn_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] instr,
  output logic        out_valid,
  output logic [1:0]  fmt,
  output logic [3:0]  op,
  output logic [3:0]  src_reg,
  output logic [3:0]  dst_reg,
  output logic        byte_op,
  output logic [2:0]  src_mode,
  output logic [2:0]  dst_mode,
  output logic        const_en,
  output logic [15:0] const_val,
  output logic [1:0]  ext_words,
  output logic [15:0] jmp_off
);
  localparam logic [2:0] M_REG = 3'd0, M_IDX = 3'd1, M_IND = 3'd2, M_INC = 3'd3,
                         M_SYM = 3'd4, M_ABS = 3'd5, M_IMM = 3'd6, M_CON = 3'd7;
  localparam logic [1:0] F_BAD = 2'd0, F_TWO = 2'd1, F_ONE = 2'd2, F_JMP = 2'd3;

  wire       is_jmp = instr[15:13] == 3'b001;
  wire       is_one = instr[15:10] == 6'b000100;
  wire       is_two = |instr[15:14];
  wire [3:0] sreg   = is_two ? instr[11:8] : instr[3:0];
  wire [1:0] as_b   = instr[5:4];

  logic [1:0]  n_fmt;
  logic [3:0]  n_op, n_sreg, n_dreg;
  logic        n_byte, n_cen;
  logic [2:0]  s_mode, d_mode, n_smode, n_dmode;
  logic [15:0] s_con, n_cval, n_off;
  logic [1:0]  n_ext;

  always_comb begin
    s_con = 16'h0;
    unique case (sreg)
      4'd0: s_mode = (as_b == 2'b01) ? M_SYM : (as_b == 2'b11) ? M_IMM : {1'b0, as_b};
      4'd2: begin
        s_mode = (as_b == 2'b00) ? M_REG : (as_b == 2'b01) ? M_ABS : M_CON;
        s_con  = (as_b == 2'b10) ? 16'd4 : (as_b == 2'b11) ? 16'd8 : 16'd0;
      end
      4'd3: begin
        s_mode = M_CON;
        s_con  = (as_b == 2'b11) ? 16'hFFFF : {14'd0, as_b};
      end
      default: s_mode = {1'b0, as_b};
    endcase
  end

  always_comb begin
    if (!instr[7])              d_mode = M_REG;
    else if (instr[3:0] == 4'd0) d_mode = M_SYM;
    else if (instr[3:0] == 4'd2) d_mode = M_ABS;
    else                         d_mode = M_IDX;
  end

  always_comb begin
    n_fmt = F_BAD; n_op = '0; n_sreg = '0; n_dreg = '0; n_byte = 1'b0;
    n_smode = M_REG; n_dmode = M_REG; n_cen = 1'b0; n_cval = '0; n_off = '0;
    if (is_two) begin
      n_fmt = F_TWO; n_op = instr[15:12]; n_sreg = instr[11:8]; n_dreg = instr[3:0];
      n_byte = instr[6]; n_smode = s_mode; n_dmode = d_mode;
    end else if (is_one) begin
      n_fmt = F_ONE; n_op = {1'b0, instr[9:7]}; n_sreg = instr[3:0]; n_dreg = instr[3:0];
      n_byte = instr[6]; n_smode = s_mode;
    end else if (is_jmp) begin
      n_fmt = F_JMP; n_op = {1'b0, instr[12:10]};
      n_off = {{5{instr[9]}}, instr[9:0], 1'b0};
    end
    if (n_smode == M_CON) begin
      n_cen  = 1'b1;
      n_cval = s_con;
    end
    n_ext = 2'(n_smode == M_IDX || n_smode == M_SYM || n_smode == M_ABS || n_smode == M_IMM)
          + 2'(n_dmode != M_REG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; fmt <= '0; op <= '0; src_reg <= '0; dst_reg <= '0;
      byte_op <= 1'b0; src_mode <= '0; dst_mode <= '0; const_en <= 1'b0;
      const_val <= '0; ext_words <= '0; jmp_off <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fmt <= n_fmt; op <= n_op; src_reg <= n_sreg; dst_reg <= n_dreg;
        byte_op <= n_byte; src_mode <= n_smode; dst_mode <= n_dmode;
        const_en <= n_cen; const_val <= n_cval; ext_words <= n_ext; jmp_off <= n_off;
      end
    end
  end
endmodule

module insn_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [1:0]  fmt,
  input logic [3:0]  op,
  input logic [2:0]  src_mode,
  input logic [2:0]  dst_mode,
  input logic        const_en,
  input logic [15:0] const_val,
  input logic [1:0]  ext_words,
  input logic [15:0] jmp_off
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !out_valid && fmt == 2'd0 && ext_words == 2'd0);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(fmt) && $stable(op) && $stable(src_mode) && $stable(const_val));
  a_r3_illegal_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fmt == 2'd0 |-> !const_en && ext_words == 2'd0 && op == 4'd0 && jmp_off == 16'd0);
  a_r6_offset_even: assert property (@(posedge clk) disable iff (!rst_n) fmt == 2'd3 |-> !jmp_off[0] && ext_words == 2'd0);
  a_r10_const_set: assert property (@(posedge clk) disable iff (!rst_n)
    const_en |-> src_mode == 3'd7 && (const_val == 16'd0 || const_val == 16'd1 || const_val == 16'd2 ||
                 const_val == 16'd4 || const_val == 16'd8 || const_val == 16'hFFFF));
  a_r11_one_op_dst: assert property (@(posedge clk) disable iff (!rst_n) fmt == 2'd2 |-> dst_mode == 3'd0);
  a_r12_ext_cap: assert property (@(posedge clk) disable iff (!rst_n) ext_words != 2'd3);
endmodule

bind insn_decoder insn_decoder_chk u_chk (.*);

// File: tb/insn_decoder_bench.sv
module insn_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic out_valid, byte_op, const_en;
  logic [1:0] fmt, ext_words;
  logic [3:0] op, src_reg, dst_reg;
  logic [2:0] src_mode, dst_mode;
  logic [15:0] const_val, jmp_off;

  insn_decoder u_insn_decoder (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int e_vld, e_fmt, e_op, e_sr, e_dr, e_byte, e_sm, e_dm, e_cen, e_cval, e_ext, e_off;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string src_tag(int r);
    if (r == 0) return "R8";
    if (r == 2) return "R9";
    if (r == 3) return "R10";
    return "R7";
  endfunction

  task automatic model(input int w);
    int top = w / 4096, rs, as_v, ad, rd, o, need;
    e_fmt = 0; e_op = 0; e_sr = 0; e_dr = 0; e_byte = 0; e_sm = 0; e_dm = 0;
    e_cen = 0; e_cval = 0; e_ext = 0; e_off = 0;
    as_v = (w / 16) % 4; ad = (w / 128) % 2; rd = w % 16;
    if (top >= 4 || (w / 1024) == 4) begin
      e_fmt = (top >= 4) ? 1 : 2;
      e_op  = (top >= 4) ? top : (w / 128) % 8;
      rs    = (top >= 4) ? (w / 256) % 16 : rd;
      e_sr = rs; e_dr = rd; e_byte = (w / 64) % 2;
      if (rs == 3) begin e_sm = 7; e_cval = (as_v == 3) ? 65535 : as_v; end
      else if (rs == 2) begin
        if (as_v == 0) e_sm = 0; else if (as_v == 1) e_sm = 5;
        else begin e_sm = 7; e_cval = (as_v == 2) ? 4 : 8; end
      end else if (rs == 0) e_sm = (as_v == 1) ? 4 : (as_v == 3) ? 6 : as_v;
      else e_sm = as_v;
      e_cen = (e_sm == 7);
      if (e_fmt == 1 && ad == 1) e_dm = (rd == 0) ? 4 : (rd == 2) ? 5 : 1;
      need = (e_sm == 1 || e_sm == 4 || e_sm == 5 || e_sm == 6) ? 1 : 0;
      e_ext = need + ((e_dm != 0) ? 1 : 0);
    end else if (w / 8192 == 1) begin
      e_fmt = 3; e_op = (w / 1024) % 8;
      o = w % 1024; if (o >= 512) o -= 1024;
      e_off = (o * 2) & 16'hFFFF;
    end
  endtask

  task automatic compare();
    string st = src_tag(e_sr);
    string ft = (e_fmt == 1) ? "R4" : (e_fmt == 2) ? "R5" : (e_fmt == 3) ? "R6" : "R3";
    string rt = rst_n ? "R2" : "R1";
    chk(rt, "out_valid", int'(out_valid), e_vld);
    chk("R3", "fmt", int'(fmt), e_fmt);
    chk(ft, "op", int'(op), e_op);
    chk(ft, "src_reg", int'(src_reg), e_sr);
    chk(ft, "dst_reg", int'(dst_reg), e_dr);
    chk("R13", "byte_op", int'(byte_op), e_byte);
    chk(st, "src_mode", int'(src_mode), e_sm);
    chk("R11", "dst_mode", int'(dst_mode), e_dm);
    chk("R10", "const_en", int'(const_en), e_cen);
    chk(st, "const_val", int'(const_val), e_cval);
    chk("R12", "ext_words", int'(ext_words), e_ext);
    chk("R6", "jmp_off", int'(jmp_off), e_off);
  endtask

  task automatic step(input bit v, input int w);
    @(negedge clk);
    compare();
    in_valid = v; instr = 16'(w);
    if (!rst_n) begin
      e_vld = 0; e_fmt = 0; e_op = 0; e_sr = 0; e_dr = 0; e_byte = 0; e_sm = 0;
      e_dm = 0; e_cen = 0; e_cval = 0; e_ext = 0; e_off = 0;
    end else begin
      e_vld = v;
      if (v) model(w);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int lfsr = 16'hACE1;
    e_vld = 0; e_fmt = 0; e_op = 0; e_sr = 0; e_dr = 0; e_byte = 0; e_sm = 0;
    e_dm = 0; e_cen = 0; e_cval = 0; e_ext = 0; e_off = 0;
    // R1: words presented during reset are not taken
    step(1, 16'h4506); step(1, 16'h5432); step(0, 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0);
    // R13 reference word, then idle cycles to check hold (R2)
    step(1, 16'h4506); step(0, 16'h1234); step(0, 16'h2000);
    // R7 R8 R9 R10: every source register class with every mode pair
    for (int r = 0; r < 5; r++)
      for (int a = 0; a < 4; a++)
        step(1, 16'h5000 | ((r == 4 ? 7 : r) << 8) | (a << 4) | 16'h0009);
    // R11 R12: indexed destinations on regs 0, 2, 9 with indexed and immediate sources
    step(1, 16'h4590); step(1, 16'h4592); step(1, 16'h4599);
    step(1, 16'h40B2); step(1, 16'h4232); step(1, 16'hF3E0);
    // R5: one-operand forms
    step(1, 16'h1005); step(1, 16'h1234); step(1, 16'h13B3); step(1, 16'h1320); step(1, 16'h1290);
    // R6: jumps at offset extremes
    step(1, 16'h2000); step(1, 16'h21FF); step(1, 16'h2200); step(1, 16'h3FFF); step(1, 16'h3C01);
    // R3: illegal and boundary words
    step(1, 16'h0000); step(1, 16'h0FFF); step(1, 16'h0C00); step(1, 16'h1400); step(1, 16'h1FFF);
    step(1, 16'h4000);
    for (int i = 0; i < 2000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0);
      step((lfsr % 5) != 0, lfsr);
    end
    step(0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule